// File: doc/BRIEF.md
# SPI Response Frame Generator

This block produces the byte stream that a SPI target returns to its master once a command has finished. A start strobe supplies the result status and the reported payload size. The block then offers one byte at a time on its output. The SPI shifter takes each byte and signals through a request strobe that it wants the next one. Payload bytes come from an external response buffer through a read port with one cycle of latency. The block fetches each payload byte early, so the byte is already held when the shifter asks for it.

A frame starts with a filler byte that tells the master a reply is still in preparation. A sync marker follows, then the status, the length, the payload and an 8-bit additive checksum. The checksum covers only the status, the length and the payload. Once the frame is exhausted, the output sits on a dedicated trailer value. A master that clocks too many bytes therefore sees a value it can recognise. A new start strobe abandons any frame in progress and begins a fresh one.

Top module: `resp_frame_gen`

## Requirements
- R1: After reset the output byte is 0xED and no buffer read is requested.
- R2: In the cycle after a start strobe the output is the filler byte 0xFA. A next-byte request moves the output to the following frame byte, which appears in the cycle after the request.
- R3: Frame order: 0xFA, sync marker 0xEC, status, length (8 bits), payload bytes in buffer address order 0 upward, checksum, then 0xED.
- R4: The checksum is the sum, modulo 256, of the status byte, the length byte and all payload bytes. The 0xFA and 0xEC bytes are not part of the sum.
- R5: With a reported size of zero, the checksum byte follows the length byte directly and equals the status.
- R6: Every byte requested after the checksum is 0xED, until the next start strobe.
- R7: If the reported size exceeds MAX_LEN, the frame carries status 0x0E and length 0, has no payload and a checksum of 0x0E, and no buffer read is made.
- R8: A start strobe during a frame abandons that frame and begins the new one at 0xFA with the new status and size.
- R9: Each payload byte is read exactly once, at addresses 0 to length-1 in ascending order. Read data is taken one cycle after the read strobe. Next-byte requests are at least two cycles apart.
- R10: Without a next-byte request or a start strobe, the output byte does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle strobe that begins a new response frame |
| status_i | input | 8 | Result status, sampled with start_i |
| size_i | input | SIZE_W | Reported payload size, sampled with start_i |
| next_i | input | 1 | Shifter request to advance to the next byte |
| rd_en_o | output | 1 | Response buffer read strobe |
| rd_addr_o | output | ADDR_W | Response buffer read address |
| rd_data_i | input | 8 | Buffer data, valid one cycle after rd_en_o |
| tx_byte_o | output | 8 | Byte currently offered to the shifter |

## Verification
The assertions check on every cycle the properties that hold locally:
- the filler byte appears after a start;
- the sync marker follows the filler;
- the output holds while there is no request;
- the trailer value repeats after the frame ends;
- a prefetched byte is present whenever the sequencer consumes one;
- read addresses stay in range;
- an oversized report never triggers a read.

Only the bench scenarios can show the correctness of whole frames, because that needs a reference computed from the stimulus:
- checksum values, including wrap-around at full length;
- payload order and read counts;
- the zero-length and oversize cases;
- a restart in the middle of a payload.

// File: rtl/resp_frame_pkg.sv
// Shared constants of the response frame generator.
// Assumes: byte-wide frame fields; payload starts after a four-byte header.
package resp_frame_pkg;
    localparam logic [7:0] BYTE_PAD   = 8'hFA;  // reply still being prepared
    localparam logic [7:0] BYTE_SOF   = 8'hEC;  // frame sync marker
    localparam logic [7:0] BYTE_PAST  = 8'hED;  // beyond end of frame
    localparam logic [7:0] STATUS_BAD = 8'h0E;  // reported size too large
    localparam int         HDR_LEN    = 4;      // pad, sync, status, length
endpackage

// File: rtl/resp_frame_fetch.sv
// Payload prefetcher: keeps the next payload byte held in a register so the
// sequencer can consume it on a request without waiting on the buffer.
// Assumes: buffer read latency of one cycle; consumes at least two cycles apart.
module resp_frame_fetch #(
    parameter int MAX_LEN = 255,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        len_i,
    input  logic              take_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic [7:0]        pre_o
);
    localparam int CNT_W = ADDR_W + 1;

    logic [CNT_W-1:0] nxt_addr_q;
    logic [7:0]       len_q;
    logic             pend_q;
    logic             pre_vld_q;
    logic [7:0]       pre_q;

    // Issue a read on start (first byte) or when a held byte is consumed.
    always_comb begin
        rd_en_o   = 1'b0;
        rd_addr_o = '0;
        if (start_i) begin
            rd_en_o = (len_i != 8'd0);
        end else if (take_i) begin
            rd_en_o   = (nxt_addr_q < CNT_W'(len_q));
            rd_addr_o = nxt_addr_q[ADDR_W-1:0];
        end
    end

    // Track next address, pending read and the held byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_addr_q <= '0;
            len_q      <= '0;
            pend_q     <= 1'b0;
            pre_vld_q  <= 1'b0;
            pre_q      <= '0;
        end else begin
            pend_q <= rd_en_o;
            if (start_i) begin
                len_q      <= len_i;
                nxt_addr_q <= CNT_W'(1);
            end else if (rd_en_o) begin
                nxt_addr_q <= nxt_addr_q + CNT_W'(1);
            end
            if (pend_q) begin
                pre_q     <= rd_data_i;
                pre_vld_q <= 1'b1;
            end else if (take_i || start_i) begin
                pre_vld_q <= 1'b0;
            end
        end
    end

    assign pre_o = pre_q;

    // R9: a consumed byte must already be held
    p_take_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> pre_vld_q);
    // R9: reads never address beyond the buffer limit
    p_read_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> (int'(rd_addr_o) < MAX_LEN));
endmodule

// File: rtl/resp_frame_sum.sv
// Checksum accumulator: seeded at frame start, adds each consumed payload byte.
// Assumes: seed already holds status plus length modulo 256.
module resp_frame_sum (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] seed_i,
    input  logic       add_i,
    input  logic [7:0] byte_i,
    output logic [7:0] sum_o
);
    logic [7:0] sum_q;

    // Running 8-bit additive sum.
    always_ff @(posedge clk) begin
        if (!rst_n)      sum_q <= '0;
        else if (load_i) sum_q <= seed_i;
        else if (add_i)  sum_q <= sum_q + byte_i;
    end

    assign sum_o = sum_q;
endmodule

// File: rtl/resp_frame_seq.sv
// Frame sequencer: walks the frame positions on each request and registers the
// byte offered to the shifter; holds the trailer value after the checksum.
// Assumes: length already limited to MAX_LEN; requests two or more cycles apart.
module resp_frame_seq
    import resp_frame_pkg::*;
#(
    parameter int MAX_LEN = 255,
    parameter int POS_W   = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       next_i,
    input  logic [7:0] status_i,
    input  logic [7:0] len_i,
    input  logic [7:0] pre_i,
    input  logic [7:0] sum_i,
    output logic       take_o,
    output logic [7:0] tx_o
);
    logic             busy_q;
    logic [POS_W-1:0] pos_q;
    logic [7:0]       st_q;
    logic [7:0]       len_q;
    logic [7:0]       tx_q;
    logic [POS_W-1:0] nxt;
    logic [POS_W-1:0] sum_pos;
    logic             in_pl;
    logic [7:0]       nxt_byte;

    // Select the byte for the next frame position.
    always_comb begin
        nxt      = pos_q + POS_W'(1);
        sum_pos  = POS_W'(HDR_LEN) + POS_W'(len_q);
        in_pl    = (nxt >= POS_W'(HDR_LEN)) && (nxt < sum_pos);
        take_o   = busy_q && next_i && !start_i && in_pl;
        nxt_byte = BYTE_PAST;
        if (nxt == POS_W'(1))      nxt_byte = BYTE_SOF;
        else if (nxt == POS_W'(2)) nxt_byte = st_q;
        else if (nxt == POS_W'(3)) nxt_byte = len_q;
        else if (in_pl)            nxt_byte = pre_i;
        else if (nxt == sum_pos)   nxt_byte = sum_i;
    end

    // Advance position and output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pos_q  <= '0;
            st_q   <= '0;
            len_q  <= '0;
            tx_q   <= BYTE_PAST;
        end else if (start_i) begin
            busy_q <= 1'b1;
            pos_q  <= '0;
            st_q   <= status_i;
            len_q  <= len_i;
            tx_q   <= BYTE_PAD;
        end else if (next_i) begin
            if (busy_q) begin
                pos_q <= nxt;
                tx_q  <= nxt_byte;
                if (nxt == sum_pos) busy_q <= 1'b0;
            end else begin
                tx_q <= BYTE_PAST;
            end
        end
    end

    assign tx_o = tx_q;

    // R2: filler byte at position zero after a start
    p_pad_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (tx_q == BYTE_PAD) && busy_q);
    // R3: sync marker follows the filler
    p_sof_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && pos_q == '0 && next_i && !start_i) |=> tx_q == BYTE_SOF);
    // R6: trailer value once the frame is over
    p_past_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && next_i && !start_i) |=> tx_q == BYTE_PAST);
    // R10: output holds without a request
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!next_i && !start_i) |=> $stable(tx_q));
    // R9: requests spaced at least two cycles apart
    p_next_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        next_i |=> !next_i);
endmodule

// File: rtl/resp_frame_gen.sv
// Response frame generator top: screens the reported size, derives the
// checksum seed and joins sequencer, prefetcher and checksum accumulator.
// Assumes: MAX_LEN between 2 and 255; SIZE_W of at least 8.
module resp_frame_gen
    import resp_frame_pkg::*;
#(
    parameter int MAX_LEN = 255,
    parameter int SIZE_W  = 9,
    parameter int ADDR_W  = $clog2(MAX_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        status_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              next_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic [7:0]        tx_byte_o
);
    localparam int POS_W = $clog2(MAX_LEN + HDR_LEN + 2);

    logic       oversize;
    logic [7:0] eff_st;
    logic [7:0] eff_len;
    logic [7:0] seed;
    logic       take;
    logic [7:0] pre_byte;
    logic [7:0] sum;

    // Replace status and drop payload when the reported size is too large.
    always_comb begin
        oversize = (size_i > SIZE_W'(MAX_LEN));
        eff_st   = oversize ? STATUS_BAD : status_i;
        eff_len  = oversize ? 8'd0 : 8'(size_i);
        seed     = eff_st + eff_len;
    end

    resp_frame_seq #(.MAX_LEN(MAX_LEN), .POS_W(POS_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .next_i   (next_i),
        .status_i (eff_st),
        .len_i    (eff_len),
        .pre_i    (pre_byte),
        .sum_i    (sum),
        .take_o   (take),
        .tx_o     (tx_byte_o)
    );

    resp_frame_fetch #(.MAX_LEN(MAX_LEN), .ADDR_W(ADDR_W)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .len_i     (eff_len),
        .take_i    (take),
        .rd_en_o   (rd_en_o),
        .rd_addr_o (rd_addr_o),
        .rd_data_i (rd_data_i),
        .pre_o     (pre_byte)
    );

    resp_frame_sum u_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (start_i),
        .seed_i (seed),
        .add_i  (take),
        .byte_i (pre_byte),
        .sum_o  (sum)
    );

    // R7: an oversized report never starts a buffer read
    p_oversize_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && size_i > SIZE_W'(MAX_LEN)) |-> !rd_en_o);
endmodule

// File: tb/sim_resp_frame_gen.sv
`timescale 1ns/100ps
module sim_resp_frame_gen;
    localparam int MAX_LEN = 255;
    localparam int SIZE_W  = 9;
    localparam int ADDR_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [7:0]        status_i = '0;
    logic [SIZE_W-1:0] size_i = '0;
    logic              next_i = 1'b0;
    logic              rd_en_o;
    logic [ADDR_W-1:0] rd_addr_o;
    logic [7:0]        rd_data_i = '0;
    logic [7:0]        tx_byte_o;

    logic [7:0] mem [256];
    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    bit addr_bad = 1'b0;

    always #2.5 clk = ~clk;

    resp_frame_gen #(.MAX_LEN(MAX_LEN), .SIZE_W(SIZE_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .status_i(status_i),
        .size_i(size_i), .next_i(next_i), .rd_en_o(rd_en_o),
        .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .tx_byte_o(tx_byte_o)
    );

    // Buffer model with one cycle of read latency, plus read bookkeeping.
    always @(posedge clk) begin
        if (rst_n && rd_en_o) begin
            rd_data_i <= mem[rd_addr_o];
            if (int'(rd_addr_o) != rd_cnt) addr_bad = 1'b1;
            rd_cnt = rd_cnt + 1;
        end
    end

    task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check_int(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fill(int seed);
        for (int i = 0; i < 256; i++) mem[i] = 8'((seed * 37) + (i * 13) + (i >> 3));
    endtask

    task automatic do_start(logic [7:0] st, logic [SIZE_W-1:0] sz);
        @(negedge clk);
        rd_cnt = 0;
        addr_bad = 1'b0;
        start_i = 1'b1; status_i = st; size_i = sz;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check8("R2 filler after start", tx_byte_o, 8'hFA);
    endtask

    task automatic pulse_next(int gap);
        repeat (gap) @(negedge clk);
        @(negedge clk);
        next_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        next_i = 1'b0;
    endtask

    // Full frame: start, walk every byte, check trailer and read bookkeeping.
    task automatic run_frame(string req, logic [7:0] st, int sz, int seed, int gap, int extra);
        logic [7:0] est, elen, sum, exp;
        int n;
        fill(seed);
        if (sz > MAX_LEN) begin est = 8'h0E; n = 0; end
        else begin est = st; n = sz; end
        elen = 8'(n);
        sum = est + elen;
        for (int i = 0; i < n; i++) sum = sum + mem[i];
        do_start(st, SIZE_W'(sz));
        for (int k = 1; k <= 4 + n + extra; k++) begin
            if (k == 1) exp = 8'hEC;
            else if (k == 2) exp = est;
            else if (k == 3) exp = elen;
            else if (k < 4 + n) exp = mem[k - 4];
            else if (k == 4 + n) exp = sum;
            else exp = 8'hED;
            pulse_next(0);
            check8(k > 4 + n ? "R6 trailer" : (k == 4 + n ? "R4 checksum" : req), tx_byte_o, exp);
            if (gap > 0) begin
                repeat (gap) @(negedge clk);
                check8("R10 hold", tx_byte_o, exp);
            end
        end
        check_int("R9 read count", rd_cnt, n);
        check_int("R9 read order", int'(addr_bad), 0);
    endtask

    task automatic t_reset;
        check8("R1 reset output", tx_byte_o, 8'hED);
        check_int("R1 no read", int'(rd_en_o), 0);
        pulse_next(0);
        check8("R1 idle request", tx_byte_o, 8'hED);
    endtask

    task automatic t_basic;     run_frame("R3 basic", 8'h00, 5, 1, 0, 2);   endtask
    task automatic t_zero;      run_frame("R5 zero length", 8'h03, 0, 2, 0, 3); endtask
    task automatic t_full;      run_frame("R3 full length", 8'hA7, 255, 3, 0, 1); endtask
    task automatic t_hold;      run_frame("R10 slow master", 8'h5C, 6, 4, 4, 2); endtask
    task automatic t_oversize;  run_frame("R7 oversize", 8'h00, 300, 5, 0, 2); endtask
    task automatic t_edge_over; run_frame("R7 size 256", 8'h11, 256, 6, 0, 1); endtask

    task automatic t_abort;
        fill(7);
        do_start(8'h22, SIZE_W'(10));
        for (int k = 0; k < 6; k++) pulse_next(0);
        check8("R8 mid payload", tx_byte_o, mem[2]);
        run_frame("R8 restart", 8'h09, 3, 8, 0, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_zero();
        t_full();
        t_hold();
        t_oversize();
        t_edge_over();
        t_abort();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule